// File: doc/BRIEF.md
# Reference qualification and holdover controller

This controller sits between a digital phase detector and the logic that steers a local oscillator. The detector delivers signed phase-error samples, each marked by a one-cycle strobe. The controller groups the samples into windows of fixed length and averages each window. A window in which no alarm appeared yields a correction value for the steering logic. A window that saw any alarm is thrown away whole. There are three alarm inputs: loss of signal, out of frame and excessive errors.

A four-state machine records how far the reference has been qualified. The states are idle, acquire, tracking and holdover. Tracking is reached only after a fixed number of clean windows in acquire. An alarm during acquire or tracking moves the controller to holdover at once. There the last correction stays on the output until a clean window brings the controller back to acquire.

The sample input is a plain strobe and carries no ready signal. Every strobed sample is accepted in its own cycle, so the block never applies back-pressure. The upstream detector needs no flow control. The correction output is likewise a single-cycle pulse with no acknowledge. The steering logic must capture the value in the cycle of the pulse.

Top module: `ref_qual_ctrl`

## Requirements
- R1: While rst_n is low and after its release, state_o reads 0 (idle), upd_o is 0 and corr_o is 0.
- R2: A window closes on the sample strobe that brings the count of accepted samples to 2^WIN_LOG2. Cycles with samp_valid low are not counted.
- R3: The correction is the window sum of the signed samples shifted right arithmetically by WIN_LOG2, which rounds toward minus infinity. A full window of full-scale samples, all -2^(SAMP_W-1) or all 2^(SAMP_W-1)-1, averages to that same value with no overflow.
- R4: A clean window drives upd_o high for exactly one cycle, in the cycle after the clock edge that accepted the window's last sample. In that same cycle corr_o carries the window's average.
- R5: If los_i, oof_i or exc_err_i is high in any cycle of a window, the window produces no update and corr_o keeps its value. This covers cycles with no sample and the cycle of the last sample.
- R6: The alarm memory clears when a window closes, so an alarm affects only the window in which it occurred.
- R7: State encoding is 0 idle, 1 acquire, 2 tracking and 3 holdover. From idle, the first clean window moves the controller to acquire. A window with an alarm leaves it in idle.
- R8: An alarm seen in acquire or tracking moves state_o to holdover in the next cycle, without waiting for the window to close.
- R9: From acquire, the controller enters tracking on the ACQ_WINDOWS-th clean window counted from entry into acquire.
- R10: In holdover, corr_o is held. A clean window issues its update, moves the controller to acquire and restarts the acquire window count from zero.
- R11: Once the controller has left idle, it never returns there except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | Phase-error sample strobe |
| samp_data | input | SAMP_W | Signed phase-error sample |
| los_i | input | 1 | Loss-of-signal alarm |
| oof_i | input | 1 | Out-of-frame alarm |
| exc_err_i | input | 1 | Excessive-error alarm |
| corr_o | output | SAMP_W | Signed averaged correction, held between updates |
| upd_o | output | 1 | One-cycle correction update strobe |
| state_o | output | 2 | Qualification state (encoding in R7) |

## Verification
The bench builds the block with SAMP_W = 12, WIN_LOG2 = 3 and ACQ_WINDOWS = 4. With these values a window is eight samples long and tracking comes after four clean acquire windows. The full path from idle to tracking, and from holdover back to tracking, therefore fits in a few hundred cycles. The 12-bit sample width puts the full-scale values -2048 and 2047 within easy reach for the overflow cases. Odd window sums exercise the floor rounding of negative averages.

// File: rtl/refq_pkg.sv
package refq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_TRK  = 2'd2,
    ST_HOLD = 2'd3
  } refq_state_e;
endpackage

// File: rtl/refq_alarm_latch.sv
// Sticky record of any alarm line seen since the last window close.
module refq_alarm_latch #(
  parameter int NUM_ALARMS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] alarm_vec,
  input  logic                  win_end,
  output logic                  alarm_now,
  output logic                  win_clean
);
  logic [NUM_ALARMS-1:0] seen_q;
  logic [NUM_ALARMS-1:0] seen_or_now;

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_line
    assign seen_or_now[g] = seen_q[g] | alarm_vec[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q[g] <= 1'b0;
      else if (win_end) seen_q[g] <= 1'b0;
      else              seen_q[g] <= seen_or_now[g];
    end
  end

  assign alarm_now = |alarm_vec;
  assign win_clean = ~(|seen_or_now);
endmodule

// File: rtl/refq_window_acc.sv
// Counts accepted samples and accumulates their sum. The average is the sum
// with its low WIN_LOG2 bits dropped, an arithmetic shift.
module refq_window_acc #(
  parameter int SAMP_W   = 16,
  parameter int WIN_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [SAMP_W-1:0] samp_data,
  output logic              win_end,
  output logic [SAMP_W-1:0] win_avg
);
  localparam int ACC_W = SAMP_W + WIN_LOG2;

  logic [WIN_LOG2-1:0] cnt_q;
  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    samp_ext;
  logic [ACC_W-1:0]    sum_full;

  assign samp_ext = {{WIN_LOG2{samp_data[SAMP_W-1]}}, samp_data};
  assign sum_full = acc_q + samp_ext;
  assign win_end  = samp_valid && (cnt_q == {WIN_LOG2{1'b1}});
  assign win_avg  = sum_full[ACC_W-1:WIN_LOG2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (samp_valid) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= win_end ? '0 : sum_full;
    end
  end
endmodule

// File: rtl/refq_state_ctrl.sv
// Qualification state machine and registered correction output.
module refq_state_ctrl
  import refq_pkg::*;
#(
  parameter int SAMP_W      = 16,
  parameter int ACQ_WINDOWS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end,
  input  logic              win_clean,
  input  logic              alarm_now,
  input  logic [SAMP_W-1:0] win_avg,
  output logic [SAMP_W-1:0] corr_o,
  output logic              upd_o,
  output refq_state_e       state_o
);
  localparam int ACQ_CW = $clog2(ACQ_WINDOWS + 1);
  localparam logic [ACQ_CW-1:0] ACQ_LAST = ACQ_CW'(ACQ_WINDOWS - 1);

  refq_state_e       st_q, st_d;
  logic [ACQ_CW-1:0] acq_q, acq_d;
  logic [SAMP_W-1:0] corr_q, corr_d;
  logic              upd_q, upd_d;

  always_comb begin
    st_d   = st_q;
    acq_d  = acq_q;
    corr_d = corr_q;
    upd_d  = 1'b0;
    if (win_end) begin
      if (win_clean) begin
        upd_d  = 1'b1;
        corr_d = win_avg;
        case (st_q)
          ST_IDLE, ST_HOLD: begin
            st_d  = ST_ACQ;
            acq_d = '0;
          end
          ST_ACQ: begin
            if (acq_q == ACQ_LAST) st_d = ST_TRK;
            else                   acq_d = acq_q + 1'b1;
          end
          default: ;
        endcase
      end else if (st_q != ST_IDLE) begin
        st_d = ST_HOLD;
      end
    end else if (alarm_now && (st_q == ST_ACQ || st_q == ST_TRK)) begin
      st_d = ST_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      acq_q  <= '0;
      corr_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      acq_q  <= acq_d;
      corr_q <= corr_d;
      upd_q  <= upd_d;
    end
  end

  assign corr_o  = corr_q;
  assign upd_o   = upd_q;
  assign state_o = st_q;
endmodule

// File: rtl/ref_qual_ctrl.sv
module ref_qual_ctrl
  import refq_pkg::*;
#(
  parameter int SAMP_W      = 16,
  parameter int WIN_LOG2    = 10,
  parameter int ACQ_WINDOWS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [SAMP_W-1:0] samp_data,
  input  logic              los_i,
  input  logic              oof_i,
  input  logic              exc_err_i,
  output logic [SAMP_W-1:0] corr_o,
  output logic              upd_o,
  output logic [1:0]        state_o
);
  localparam int NUM_ALARMS = 3;

  logic                  win_end;
  logic                  win_clean;
  logic                  alarm_now;
  logic [SAMP_W-1:0]     win_avg;
  logic [NUM_ALARMS-1:0] alarm_vec;
  refq_state_e           st;

  assign alarm_vec = {exc_err_i, oof_i, los_i};

  refq_window_acc #(.SAMP_W(SAMP_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .win_end(win_end), .win_avg(win_avg)
  );

  refq_alarm_latch #(.NUM_ALARMS(NUM_ALARMS)) u_alm (
    .clk(clk), .rst_n(rst_n), .alarm_vec(alarm_vec), .win_end(win_end),
    .alarm_now(alarm_now), .win_clean(win_clean)
  );

  refq_state_ctrl #(.SAMP_W(SAMP_W), .ACQ_WINDOWS(ACQ_WINDOWS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_clean(win_clean),
    .alarm_now(alarm_now), .win_avg(win_avg), .corr_o(corr_o), .upd_o(upd_o),
    .state_o(st)
  );

  assign state_o = st;
endmodule

// File: rtl/refq_checker.sv
module refq_checker #(
  parameter int SAMP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              los_i,
  input logic              oof_i,
  input logic              exc_err_i,
  input logic              win_end,
  input logic              win_clean,
  input logic [SAMP_W-1:0] corr_o,
  input logic              upd_o,
  input logic [1:0]        state_o
);
  // R4: the update is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R4: a clean window close is followed by an update
  a_r4_clean_updates: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_clean) |=> upd_o);

  // R5: a window with an alarm issues no update
  a_r5_dirty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_clean) |=> !upd_o);

  // R5 and R10: the correction changes only together with an update
  a_r10_corr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(corr_o));

  // R8: an alarm in acquire or tracking forces holdover next cycle
  a_r8_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((los_i || oof_i || exc_err_i) && (state_o == 2'd1 || state_o == 2'd2))
      |=> state_o == 2'd3);

  // R9: tracking is entered only from acquire
  a_r9_trk_from_acq: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> $past(state_o) == 2'd1);

  // R11: idle is never re-entered
  a_r11_no_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |=> (state_o != 2'd0));
endmodule

bind ref_qual_ctrl refq_checker #(.SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .los_i(los_i), .oof_i(oof_i), .exc_err_i(exc_err_i),
  .win_end(win_end), .win_clean(win_clean), .corr_o(corr_o), .upd_o(upd_o),
  .state_o(state_o)
);

// File: tb/tb_ref_qual_ctrl.sv
module tb_ref_qual_ctrl;
  localparam int SW = 12;
  localparam int WL = 3;
  localparam int WN = 1 << WL;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          samp_valid = 1'b0;
  logic [SW-1:0] samp_data = '0;
  logic          los_i = 1'b0, oof_i = 1'b0, exc_err_i = 1'b0;
  logic [SW-1:0] corr_o;
  logic          upd_o;
  logic [1:0]    state_o;

  ref_qual_ctrl #(.SAMP_W(SW), .WIN_LOG2(WL), .ACQ_WINDOWS(AW)) dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .los_i(los_i), .oof_i(oof_i), .exc_err_i(exc_err_i),
    .corr_o(corr_o), .upd_o(upd_o), .state_o(state_o)
  );

  int n_chk = 0, n_fail = 0;
  int ex_state, ex_acq, ex_corr, ex_upd, acc, cnt;
  bit dirty;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ex_state = 0; ex_acq = 0; ex_corr = 0; ex_upd = 0;
    acc = 0; cnt = 0; dirty = 0;
  endtask

  // one clock cycle: drive, advance the model, check at the next edge + 1
  task automatic step(bit v, int d, int akind, string tag);
    bit alarm;
    bit closed;
    samp_valid = v;
    samp_data  = d[SW-1:0];
    los_i      = (akind == 0);
    oof_i      = (akind == 1);
    exc_err_i  = (akind == 2);
    alarm  = (akind >= 0);
    closed = 0;
    ex_upd = 0;
    if (alarm) dirty = 1;
    if (v) begin
      acc += d;
      cnt++;
      if (cnt == WN) begin
        closed = 1;
        if (!dirty) begin
          ex_upd  = 1;
          ex_corr = (acc >>> WL) & ((1 << SW) - 1);
          if (ex_state == 0 || ex_state == 3) begin
            ex_state = 1; ex_acq = 0;
          end else if (ex_state == 1) begin
            ex_acq++;
            if (ex_acq == AW) ex_state = 2;
          end
        end else if (ex_state != 0) begin
          ex_state = 3;
        end
        acc = 0; cnt = 0; dirty = 0;
      end
    end
    if (!closed && alarm && (ex_state == 1 || ex_state == 2)) ex_state = 3;
    @(posedge clk);
    #1;
    chk({tag, " state"}, int'(state_o), ex_state);
    chk({tag, " upd"}, int'(upd_o), ex_upd);
    chk({tag, " corr"}, int'(corr_o), ex_corr);
  endtask

  // amode: 0 none, 1 alarm on sample aidx, 2 alarm on a gap cycle before it
  task automatic window(int base, int stp, int gap, int amode, int akind,
                        int aidx, string tag);
    for (int i = 0; i < WN; i++) begin
      for (int g = 0; g < gap; g++)
        step(0, 0, (amode == 2 && aidx == i) ? akind : -1, tag);
      step(1, base + i * stp, (amode == 1 && aidx == i) ? akind : -1, tag);
    end
    step(0, 0, -1, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state in reset", int'(state_o), 0);
    chk("R1 upd in reset", int'(upd_o), 0);
    chk("R1 corr in reset", int'(corr_o), 0);
    rst_n = 1'b1;
    step(0, 0, -1, "R1");
  endtask

  task automatic t_idle_dirty();      // R7 and R5: alarm window in idle
    window(100, 1, 0, 1, 0, 3, "R7");
    chk("R7 still idle", int'(state_o), 0);
  endtask

  task automatic t_first_clean();     // R4 and R7: first qualification
    window(100, 3, 0, 0, -1, 0, "R4");
    chk("R7 acquire entered", int'(state_o), 1);
  endtask

  task automatic t_neg_gaps();        // R2 and R3: gaps, floor rounding
    window(-5, -1, 2, 0, -1, 0, "R2");
    chk("R3 floor of -68/8", int'($signed(corr_o)), -9);
  endtask

  task automatic t_full_scale();      // R3: no overflow at full scale
    window(-2048, 0, 0, 0, -1, 0, "R3");
    chk("R3 min full scale", int'($signed(corr_o)), -2048);
    window(2047, 0, 1, 0, -1, 0, "R3");
    chk("R3 max full scale", int'($signed(corr_o)), 2047);
  endtask

  task automatic t_reach_track();     // R9
    window(0, 1, 0, 0, -1, 0, "R9");
    chk("R9 tracking", int'(state_o), 2);
  endtask

  task automatic t_track_alarm();     // R8 and R5
    window(50, 2, 0, 1, 1, 4, "R8");
    chk("R8 holdover", int'(state_o), 3);
  endtask

  task automatic t_gap_alarm();       // R5 and R10: alarm with no sample
    window(10, 1, 1, 2, 2, 5, "R5");
    chk("R10 still holdover", int'(state_o), 3);
  endtask

  task automatic t_recover();         // R6 and R10
    window(-40, 5, 0, 0, -1, 0, "R6");
    chk("R10 back to acquire", int'(state_o), 1);
    for (int k = 0; k < AW - 1; k++) window(7 * k, 1, 0, 0, -1, 0, "R10");
    chk("R10 count restarted", int'(state_o), 1);
    window(3, 0, 0, 0, -1, 0, "R9");
    chk("R9 tracking again", int'(state_o), 2);
  endtask

  task automatic t_last_alarm();      // R5: alarm on the final sample
    window(20, 1, 0, 1, 0, WN - 1, "R5");
    chk("R5 last sample alarm", int'(state_o), 3);
    window(1, 0, 0, 1, 2, 0, "R11");
    chk("R11 not idle", int'(state_o) != 0, 1);
  endtask

  initial begin
    t_reset();
    t_idle_dirty();
    t_first_clean();
    t_neg_gaps();
    t_full_scale();
    t_reach_track();
    t_track_alarm();
    t_gap_alarm();
    t_recover();
    t_last_alarm();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule